// File: doc/BRIEF.md
# End-of-Write Status Read Responder

This block sits in the read-data path of a byte-wide flash memory model. While the command logic reports that an internal program or erase is running, reads do not return array data. They return two completion indicators at the same time. The first is a data-polling bit on bit 7. It holds the inverted bit 7 of the byte being programmed, or a constant 0 during an erase. The second is a toggle bit on bit 6, which flips with every read access for as long as the operation runs.

When the busy flag drops, bit 7 shows true array data at once. Bit 6 stops changing. The lower six bits stay undefined for a parameterised number of clock cycles, and during that window they carry a fixed filler pattern. After the window, reads pass the array byte through unchanged.

The command block supplies the busy flag, the operation kind and the programmed byte. The block samples the operation kind and the programmed byte in the cycle where busy is first seen. Both status bits react to the read strobe and never to idle clocks.

Top module: `wstat_resp`

## Requirements
- R1: In the idle phase, `rd_data_o` equals `array_data_i` on every cycle, with or without a read strobe.
- R2: During a program operation, bit 7 of the read data is the inverse of bit 7 of the byte captured when the operation started.
- R3: During an erase operation (`op_erase_i` = 1 at start), bit 7 of the read data is 0.
- R4: During a busy operation, bit 6 of the read data is the toggle state, and that state inverts after every cycle in which `rd_strobe_i` is high. Consecutive reads therefore alternate. The toggle state is 0 after reset.
- R5: The toggle state is held on cycles without a read strobe, and on reads in the idle or settle phase.
- R6: In the busy and settle phases, bits 5 to 0 of the read data equal the parameter `FILLER`.
- R7: After busy falls, a settle phase lasts exactly `SETTLE_CYC` cycles. In it, bit 7 equals `array_data_i[7]` and bit 6 holds the frozen toggle state. Afterwards the block is idle (R1).
- R8: The operation kind and the programmed byte are captured in the cycle where busy is first sampled high. Changes to `op_erase_i` or `prog_data_i` during the operation have no effect.
- R9: Status output begins in the cycle after `busy_i` is first sampled high. Until then, read data is unchanged. A busy rise during the settle phase starts a new operation with fresh capture.
- R10: After reset the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| busy_i | input | 1 | Internal program/erase in progress |
| op_erase_i | input | 1 | 1 = erase, 0 = program |
| prog_data_i | input | 8 | Byte being programmed |
| rd_strobe_i | input | 1 | Read access in this cycle |
| array_data_i | input | 8 | Array read data |
| rd_data_o | output | 8 | Read data returned to the host |

## Verification
The bench changes the operation kind and the programmed byte in the middle of an operation. A design that samples these inputs live instead of capturing them would flip bit 7. It inserts idle clocks between busy reads, and reads during settle and idle. A toggle that advances on clocks, or outside busy, would break the expected alternation seen on the next operation. It counts settle reads one cycle at a time, and it changes array bit 7 inside the window, so an off-by-one window length or a stale bit 7 shows up directly. It also restarts an operation during settle and checks read data in the cycle where busy is raised. This catches a combinational bypass of the capture register.

// File: rtl/wstat_pkg.sv
package wstat_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_BUSY   = 2'd1,
    PH_SETTLE = 2'd2
  } phase_e;
endpackage

// File: rtl/wstat_ctrl.sv
module wstat_ctrl
  import wstat_pkg::*;
#(
  parameter int SETTLE_CYC = 100,
  localparam int CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       busy_i,
  input  logic       op_erase_i,
  input  logic       prog_bit7_i,
  output phase_e     phase_o,
  output logic       erase_o,
  output logic       pbit7_o
);
  phase_e          phase_q;
  logic [CW-1:0]   cnt_q;
  logic            erase_q, pbit7_q;
  logic            start;

  assign start = busy_i && (phase_q != PH_BUSY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      erase_q <= 1'b0;
      pbit7_q <= 1'b0;
    end else begin
      if (start) begin
        phase_q <= PH_BUSY;
        erase_q <= op_erase_i;
        pbit7_q <= prog_bit7_i;
      end else begin
        case (phase_q)
          PH_BUSY: if (!busy_i) begin
            phase_q <= (SETTLE_CYC == 0) ? PH_IDLE : PH_SETTLE;
            cnt_q   <= CW'(SETTLE_CYC - 1);
          end
          PH_SETTLE: begin
            if (cnt_q == '0) phase_q <= PH_IDLE;
            else             cnt_q   <= cnt_q - 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign phase_o = phase_q;
  assign erase_o = erase_q;
  assign pbit7_o = pbit7_q;

  // R9
  busy_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && phase_q != PH_BUSY) |=> (phase_q == PH_BUSY));
  // R8
  capture_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_BUSY && $past(phase_q) == PH_BUSY) |-> ($stable(pbit7_q) && $stable(erase_q)));
  // R7
  settle_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_SETTLE) |-> (int'(cnt_q) < SETTLE_CYC));
endmodule

// File: rtl/wstat_toggle.sv
module wstat_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_strobe_i,
  input  logic busy_ph_i,
  output logic tog_o
);
  logic tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      tog_q <= 1'b0;
    else if (rd_strobe_i && busy_ph_i) tog_q <= ~tog_q;
  end

  assign tog_o = tog_q;

  // R5
  tog_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_strobe_i |=> $stable(tog_o));
  // R4
  tog_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_strobe_i && busy_ph_i) |=> (tog_o != $past(tog_o)));
endmodule

// File: rtl/wstat_mux.sv
module wstat_mux
  import wstat_pkg::*;
#(
  parameter logic [5:0] FILLER = 6'h00
) (
  input  phase_e     phase_i,
  input  logic       erase_i,
  input  logic       pbit7_i,
  input  logic       tog_i,
  input  logic [7:0] array_data_i,
  output logic [7:0] rd_data_o
);
  always_comb begin
    case (phase_i)
      PH_BUSY:   rd_data_o = {(erase_i ? 1'b0 : ~pbit7_i), tog_i, FILLER};
      PH_SETTLE: rd_data_o = {array_data_i[7], tog_i, FILLER};
      default:   rd_data_o = array_data_i;
    endcase
  end
endmodule

// File: rtl/wstat_resp.sv
module wstat_resp
  import wstat_pkg::*;
#(
  parameter int         SETTLE_CYC = 100,
  parameter logic [5:0] FILLER     = 6'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       busy_i,
  input  logic       op_erase_i,
  input  logic [7:0] prog_data_i,
  input  logic       rd_strobe_i,
  input  logic [7:0] array_data_i,
  output logic [7:0] rd_data_o
);
  phase_e phase;
  logic   erase, pbit7, tog;

  wstat_ctrl #(.SETTLE_CYC(SETTLE_CYC)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .busy_i      (busy_i),
    .op_erase_i  (op_erase_i),
    .prog_bit7_i (prog_data_i[7]),
    .phase_o     (phase),
    .erase_o     (erase),
    .pbit7_o     (pbit7)
  );

  wstat_toggle u_tog (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_strobe_i (rd_strobe_i),
    .busy_ph_i   (phase == PH_BUSY),
    .tog_o       (tog)
  );

  wstat_mux #(.FILLER(FILLER)) u_mux (
    .phase_i      (phase),
    .erase_i      (erase),
    .pbit7_i      (pbit7),
    .tog_i        (tog),
    .array_data_i (array_data_i),
    .rd_data_o    (rd_data_o)
  );

  // R3
  erase_poll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_BUSY && erase) |-> (rd_data_o[7] == 1'b0));
  // R6
  filler_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase != PH_IDLE) |-> (rd_data_o[5:0] == FILLER));
endmodule

// File: tb/sim_wstat_resp.sv
module sim_wstat_resp;
  localparam int         SC   = 4;
  localparam logic [5:0] FILL = 6'h2A;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       busy_i = 1'b0, op_erase_i = 1'b0, rd_strobe_i = 1'b0;
  logic [7:0] prog_data_i = 8'h00, array_data_i = 8'h00;
  logic [7:0] rd_data_o;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       etog = 1'b0;

  always #5 clk_i = ~clk_i;

  wstat_resp #(.SETTLE_CYC(SC), .FILLER(FILL)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy_i), .op_erase_i(op_erase_i),
    .prog_data_i(prog_data_i), .rd_strobe_i(rd_strobe_i),
    .array_data_i(array_data_i), .rd_data_o(rd_data_o));

  task automatic step();
    @(posedge clk_i); #2;
  endtask

  // driver: push expected item, issue one read cycle
  task automatic rd(input logic [7:0] e, input string t);
    rd_strobe_i = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    step();
    rd_strobe_i = 1'b0;
  endtask

  // busy-phase read: expected uses and then advances the bench toggle
  task automatic rd_busy(input logic b7, input string t);
    rd({b7, etog, FILL}, t);
    etog = ~etog;
  endtask

  task automatic chk(input logic [7:0] e, input string t);
    #1;
    checks++;
    if (rd_data_o !== e) begin
      errors++;
      $display("FAIL %s actual %h expected %h", t, rd_data_o, e);
    end
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rd_strobe_i) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard actual %h expected none", rd_data_o);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data_o !== e) begin
          errors++;
          $display("FAIL %s actual %h expected %h", t, rd_data_o, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_ni = 1'b1;
    step();
    array_data_i = 8'h3C;
    chk(8'h3C, "R10 reset idle");
    rd(8'h3C, "R1 idle read");
    rd(8'h3C, "R5 idle read no toggle");

    // program, data bit7 = 1
    prog_data_i = 8'h80; op_erase_i = 1'b0; busy_i = 1'b1;
    chk(8'h3C, "R9 no status before edge");
    step();
    prog_data_i = 8'h00; op_erase_i = 1'b1;  // must be ignored
    rd_busy(1'b0, "R2 R4 R8 prog read 1");
    rd_busy(1'b0, "R4 prog read 2");
    step(); step();
    rd_busy(1'b0, "R5 hold over idle clocks");
    chk({1'b0, etog, FILL}, "R6 filler busy");

    // settle
    busy_i = 1'b0; array_data_i = 8'hC5;
    step();
    rd({1'b1, etog, FILL}, "R7 settle 0");
    array_data_i = 8'h45;
    rd({1'b0, etog, FILL}, "R7 settle 1 bit7 follows array");
    rd({1'b0, etog, FILL}, "R5 settle 2 frozen");
    rd({1'b0, etog, FILL}, "R6 settle 3");
    rd(8'h45, "R7 R1 passthrough after settle");

    // erase
    array_data_i = 8'h00; op_erase_i = 1'b1; busy_i = 1'b1;
    step();
    rd_busy(1'b0, "R3 erase read 1");
    rd_busy(1'b0, "R3 erase read 2");
    op_erase_i = 1'b0; prog_data_i = 8'h00;
    rd_busy(1'b0, "R8 erase kind held");
    busy_i = 1'b0; array_data_i = 8'hFF;
    step();
    rd({1'b1, etog, FILL}, "R7 erase done bit7");
    rd({1'b1, etog, FILL}, "R5 toggle stopped");

    // restart during settle, program bit7 = 0
    prog_data_i = 8'h7F; op_erase_i = 1'b0; busy_i = 1'b1;
    step();
    rd_busy(1'b1, "R9 R2 restart in settle");
    busy_i = 1'b0;
    step();
    repeat (SC) step();
    array_data_i = 8'h5A;
    chk(8'h5A, "R7 idle after window");
    rd(8'h5A, "R1 final read");

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard actual %0d expected 0 pending", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule